// File: doc/BRIEF.md
# Two-Level DMA Channel Priority Arbiter

This block decides which of N DMA channels owns a single shared transfer engine for the next data item. Each channel presents a request line, an enable bit and a 2-bit programmable priority level. The arbiter first looks for the highest level among the enabled, requesting channels. If several channels share that level, the lowest channel number wins.

A decision is made only while no grant is held. The chosen channel then keeps the grant until the engine signals the end of the item on `itemDone`. The grant appears as a one-hot vector, a binary index and a valid flag. The per-channel acknowledge rises when service of that channel begins and falls once the item is complete.

The requester is expected to drop its request after it sees acknowledge. It may raise a new request once acknowledge has gone low. The cycle after `itemDone` always carries no grant, and requests seen in that cycle are arbitrated for the following one. Priority levels can be rewritten at any time. A new value is only used by the next decision.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is active, and in the first cycle after it, `grantValid` is 0 and `grantOh`, `grantIdx` and `ackOut` are all zero.
- R2: Channel i's level is `prioLvl[2i+1:2i]`, with 3 as the highest (very high), then 2 (high), 1 (medium) and 0 (low). At a decision, a channel whose level is strictly highest among the active channels wins.
- R3: When several active channels share the highest level, the one with the smallest index wins.
- R4: A channel with `chanEn[i]` = 0 never takes part in a decision, whatever its `reqIn[i]` shows.
- R5: If no grant is held in cycle t and at least one channel is active (request and enable both 1), then in cycle t+1 `grantValid` is 1, `grantOh` has only the winner's bit set, and `grantIdx` holds the winner's number in binary.
- R6: While a grant is held, `grantOh`, `grantIdx` and `grantValid` do not change until a cycle in which `itemDone` is 1. In the following cycle `grantValid` is 0 and the grant is cleared.
- R7: If no grant is held and no channel is active, the next cycle has `grantValid` = 0 and `grantOh` = 0.
- R8: An `itemDone` pulse while no grant is held has no effect.
- R9: Changes to `prioLvl`, `reqIn` or `chanEn` while a grant is held do not alter that grant. The levels in force in the first idle cycle after the item decide the next winner.
- R10: `ackOut` equals `grantOh` in every cycle, and `grantIdx` is zero whenever `grantValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | N | Per-channel transfer request |
| chanEn | input | N | Per-channel enable; a 0 masks the channel out |
| prioLvl | input | 2*N | Packed 2-bit priority level per channel, channel i at bits 2i+1:2i |
| itemDone | input | 1 | High for one cycle when the current item's service ends |
| grantOh | output | N | One-hot grant of the channel being served |
| grantIdx | output | log2(N) | Binary index of the granted channel |
| grantValid | output | 1 | A grant is held |
| ackOut | output | N | Per-channel acknowledge, high while that channel is served |

## Verification
The embedded assertions cover the properties that hold on every cycle. The grant must be one-hot or empty, the valid flag must agree with it, and the index must agree with the one-hot vector. A held grant must stay stable until `itemDone` and must clear in the cycle after it. An idle cycle with an active channel must lead to a grant, and an idle cycle with none must stay empty. Which channel wins is shown by the bench's scenarios. It sweeps every request pattern against every level assignment, and it sweeps every enable mask. It also changes the levels in mid-item to show that a held grant is left alone and that the new levels rule the next decision.

// File: rtl/dma_prio_arb_pkg.sv
package dma_prio_arb_pkg;

  // Strobes from the control FSM into the grant datapath.
  typedef struct packed {
    logic loadGrant;   // capture the picker's winner
    logic clearGrant;  // drop the held grant
  } arbStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arbState_e;

endpackage

// File: rtl/dma_prio_arb_pick.sv
module dma_prio_arb_pick #(
  parameter int N    = 8,
  parameter int LVLW = 2,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      act,
  input  logic [N*LVLW-1:0] lvlFlat,
  output logic              pickValid,
  output logic [N-1:0]      pickOh,
  output logic [IDXW-1:0]   pickIdx
);
  localparam int NLVL = 1 << LVLW;

  // One bucket per level: which active channels sit at that level.
  logic [NLVL-1:0][N-1:0] hitByLvl;
  logic [N-1:0]           topHits;

  genvar gl, gi;
  generate
    for (gl = 0; gl < NLVL; gl++) begin : g_lvl
      for (gi = 0; gi < N; gi++) begin : g_ch
        assign hitByLvl[gl][gi] = act[gi] && (lvlFlat[gi*LVLW +: LVLW] == LVLW'(gl));
      end
    end
  endgenerate

  // First stage: highest non-empty level bucket.
  always_comb begin
    logic found;
    found   = 1'b0;
    topHits = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (!found && (|hitByLvl[l])) begin
        topHits = hitByLvl[l];
        found   = 1'b1;
      end
    end
  end

  // Second stage: lowest channel number inside that bucket.
  assign pickOh    = topHits & (~topHits + N'(1));
  assign pickValid = |act;

  always_comb begin
    pickIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (topHits[i]) pickIdx = IDXW'(i);
    end
  end

endmodule

// File: rtl/dma_prio_arb_ctrl.sv
module dma_prio_arb_ctrl
  import dma_prio_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyAct,
  input  logic        itemDone,
  output arbStrobes_t strb
);
  arbState_e state, stateNxt;

  always_comb begin
    stateNxt        = state;
    strb.loadGrant  = 1'b0;
    strb.clearGrant = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (anyAct) begin
          strb.loadGrant = 1'b1;
          stateNxt       = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (itemDone) begin
          strb.clearGrant = 1'b1;
          stateNxt        = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !itemDone) |=> (state == ST_BUSY));

  // R8
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !anyAct) |=> (state == ST_IDLE));

endmodule

// File: rtl/dma_prio_arb_dp.sv
module dma_prio_arb_dp
  import dma_prio_arb_pkg::*;
#(
  parameter int N    = 8,
  parameter int LVLW = 2,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strb,
  input  logic [N-1:0]      reqIn,
  input  logic [N-1:0]      chanEn,
  input  logic [N*LVLW-1:0] prioLvl,
  output logic              anyAct,
  output logic [N-1:0]      grantOh,
  output logic [IDXW-1:0]   grantIdx,
  output logic              grantValid,
  output logic [N-1:0]      ackOut
);
  logic [N-1:0]    actVec;
  logic            pickValid;
  logic [N-1:0]    pickOh;
  logic [IDXW-1:0] pickIdx;

  // R4: enable masks the request before any comparison.
  assign actVec = reqIn & chanEn;
  assign anyAct = |actVec;

  dma_prio_arb_pick #(.N(N), .LVLW(LVLW)) pick_i (
    .act      (actVec),
    .lvlFlat  (prioLvl),
    .pickValid(pickValid),
    .pickOh   (pickOh),
    .pickIdx  (pickIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOh    <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else if (strb.clearGrant) begin
      grantOh    <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else if (strb.loadGrant) begin
      grantOh    <= pickOh;
      grantIdx   <= pickIdx;
      grantValid <= pickValid;
    end
  end

  // Service begins with the grant, so acknowledge follows it.
  assign ackOut = grantOh;

  // R5
  idx_matches_oh_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantOh == (N'(1) << grantIdx)));

  // R10
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantIdx == '0 && grantOh == '0));

  // R4
  grant_was_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadGrant |=> ((grantOh & ~$past(actVec)) == '0));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_prio_arb_pkg::*;
#(
  parameter int N    = 8,
  localparam int LVLW = 2,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      reqIn,
  input  logic [N-1:0]      chanEn,
  input  logic [N*LVLW-1:0] prioLvl,
  input  logic              itemDone,
  output logic [N-1:0]      grantOh,
  output logic [IDXW-1:0]   grantIdx,
  output logic              grantValid,
  output logic [N-1:0]      ackOut
);
  arbStrobes_t strb;
  logic        anyAct;

  dma_prio_arb_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .anyAct  (anyAct),
    .itemDone(itemDone),
    .strb    (strb)
  );

  dma_prio_arb_dp #(.N(N), .LVLW(LVLW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqIn     (reqIn),
    .chanEn    (chanEn),
    .prioLvl   (prioLvl),
    .anyAct    (anyAct),
    .grantOh   (grantOh),
    .grantIdx  (grantIdx),
    .grantValid(grantValid),
    .ackOut    (ackOut)
  );

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh) && (grantValid == (grantOh != '0)));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !itemDone) |=> (grantValid && $stable(grantOh) && $stable(grantIdx)));

  // R6
  grant_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && itemDone) |=> !grantValid);

  // R5
  decide_when_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && (|(reqIn & chanEn))) |=> grantValid);

  // R7
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && !(|(reqIn & chanEn))) |=> !grantValid);

  // R10
  ack_follows_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut == grantOh);

endmodule

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic [N-1:0] chanEn = '0;
  logic [2*N-1:0] prioLvl = '0;
  logic         itemDone = 1'b0;
  logic [N-1:0] grantOh;
  logic [1:0]   grantIdx;
  logic         grantValid;
  logic [N-1:0] ackOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_prio_arb #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .chanEn(chanEn), .prioLvl(prioLvl),
    .itemDone(itemDone), .grantOh(grantOh), .grantIdx(grantIdx),
    .grantValid(grantValid), .ackOut(ackOut)
  );

  // Expected winner from the requirements: -1 when nobody is active.
  function automatic int expWin(logic [3:0] r, logic [3:0] e, logic [7:0] l);
    int best = -1;
    for (int i = 0; i < 4; i++) begin
      if (r[i] && e[i]) begin
        if (best < 0 || l[2*i +: 2] > l[2*best +: 2]) best = i;
      end
    end
    return best;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Compare all outputs against an expected winner (-1 = none).
  task automatic chkGrant(input string tag, input int w);
    int eOh  = (w < 0) ? 0 : (1 << w);
    int eIdx = (w < 0) ? 0 : w;
    chk({tag, " grantValid"}, int'(grantValid), (w < 0) ? 0 : 1);
    chk({tag, " grantOh"}, int'(grantOh), eOh);
    chk({tag, " grantIdx"}, int'(grantIdx), eIdx);
    chk({tag, " ackOut"}, int'(ackOut), eOh);
  endtask

  // One decision from idle, then release it with itemDone.
  task automatic decideAndRelease(input string tag, input logic [3:0] r,
                                  input logic [3:0] e, input logic [7:0] l);
    int w = expWin(r, e, l);
    reqIn = r; chanEn = e; prioLvl = l; itemDone = 1'b0;
    @(negedge clk);
    chkGrant(tag, w);
    reqIn = '0; itemDone = 1'b1;
    @(negedge clk);
    chkGrant((w < 0) ? "R8 done while idle" : "R6 release", -1);
    itemDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reqIn = 4'hF; chanEn = 4'hF;
    chkGrant("R1 in reset", -1);
    @(negedge clk);
    rstN = 1'b1;
    reqIn = '0;
    @(negedge clk);
    chkGrant("R1 after reset", -1);

    // R2 R3 R7 R10: every request pattern against every level set
    for (int l = 0; l < 256; l++) begin
      for (int r = 0; r < 16; r++) begin
        decideAndRelease("R2/R3 sweep", 4'(r), 4'hF, 8'(l));
      end
    end

    // R4: every enable mask against every request pattern
    for (int e = 0; e < 16; e++) begin
      for (int r = 0; r < 16; r++) begin
        decideAndRelease("R4 enable mask", 4'(r), 4'(e), 8'b10_01_11_00);
      end
    end

    // R6 R9: hold the grant while inputs and levels churn
    reqIn = 4'hF; chanEn = 4'hF; prioLvl = 8'b01_01_01_01;
    @(negedge clk);
    chkGrant("R5 equal levels", 0);
    for (int k = 0; k < 6; k++) begin
      reqIn = 4'(k + 8); chanEn = 4'(15 - k); prioLvl = 8'(8'hC0 + k);
      @(negedge clk);
      chkGrant("R9 held grant unchanged", 0);
    end
    // channel 3 now very high; requests stay up through the done cycle
    reqIn = 4'hF; chanEn = 4'hF; prioLvl = 8'b11_00_00_00; itemDone = 1'b1;
    @(negedge clk);
    chkGrant("R6 release with requests up", -1);
    itemDone = 1'b0;
    @(negedge clk);
    chkGrant("R9 new levels used", 3);
    // done arriving later still releases
    reqIn = '0;
    repeat (3) @(negedge clk);
    chkGrant("R6 hold without done", 3);
    itemDone = 1'b1;
    @(negedge clk);
    chkGrant("R6 release late", -1);
    itemDone = 1'b0;
    @(negedge clk);
    chkGrant("R7 nothing active", -1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule